// File: doc/BRIEF.md
# Tag Read Block Sequencer

This block drives the read side of a contactless identification tag. It addresses an external memory of eight 33-bit blocks and turns their contents into a serial bit stream with a matching bit-clock strobe. Block 0 holds the configuration word. Bit 0 of every block is a lock bit. An external modulator encodes the stream and switches the coil load.

After reset the sequencer spends a fixed setup time holding block 0 on the address bus with modulation disabled. It then sends blocks 1 up to a configured last block, and after that it starts again from block 1. Before every block it takes one field clock to reload the mode register from block 0. Single-period terminator marks can be added before each block, and a pair of them can be added after the last block. The terminator flag tells the modulator to apply continuous damping for that period.

When a write controller has finished programming a block, it pulses a resume strobe with a block number. Readout then restarts at that block and sends it with the mode that was already loaded.

Top module: `tagReadSeq`

## Requirements
- R1: After reset is released, `memAddr` stays 0 and `modEnable` stays low for 256 field clocks. `modEnable` rises after the 256th rising edge. The first `bitStrobe` pulse is seen after the 258th edge: one edge for the refresh cycle and one edge to register the first bit.
- R2: The rate field (config bits [3:1]) sets the bit period. Codes 0 to 7 give 8, 16, 32, 40, 50, 64, 100 and 128 field clocks per bit.
- R3: Each block sends its bits 1 to 32, bit 1 first. Blocks go from 1 up to the last-block field (config bits [6:4]) and then wrap to 1. A last-block value of 0 acts as 1.
- R4: Block 0 and bit 0 (the lock bit) of any block never appear as data on `txBit`.
- R5: The mode register is reloaded from block 0 in a one-clock refresh cycle before every block. That cycle lengthens the gap at each block boundary by one field clock.
- R6: When config bit 7 is set, one terminator period comes before every block. During a terminator period `termFlag` is 1 and `txBit` is 1.
- R7: When config bit 8 is set, two terminator periods follow the last block, before the wrap to block 1.
- R8: A `resumeLoad` pulse after setup restarts readout at `resumeAddr`, where 0 means block 1. The restarted block is preceded by one terminator period if bit 7 or bit 8 is set. It is sent with the previously loaded mode, and the new mode applies from the next block on.
- R9: `bitStrobe` is a one-cycle pulse that starts each bit period. `txBit` and `termFlag` change only in a cycle where `bitStrobe` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Field clock |
| rstN | input | 1 | Active-low reset (power-on) |
| memData | input | 33 | Contents of the addressed block, bit 0 is the lock bit |
| resumeLoad | input | 1 | One-cycle strobe to restart readout after programming |
| resumeAddr | input | 3 | Block number to restart at |
| memAddr | output | 3 | Block address to the memory |
| txBit | output | 1 | Serial data to the modulator |
| bitStrobe | output | 1 | Start-of-bit-period pulse |
| termFlag | output | 1 | Current period is a terminator |
| modEnable | output | 1 | Modulation allowed (low during setup) |

## Verification
The bench runs the stream under eight configurations that cover every rate code and the last-block values 0, 1, 2 and 3. The mix of terminator settings shows whether block marks, sequence marks, both or neither end up in the expected places, and it also checks that a last-block value of 0 behaves like 1. Changing block 0 while readout is running separates a design that refreshes its mode before each block from one that latches the mode only once. A resume issued at the same moment as a rate change shows that the resumed block and its trailing marks keep the old period while the following block uses the new one.

// File: rtl/tag_seq_pkg.sv
package tag_seq_pkg;
  localparam int DATA_BITS = 32;
  localparam int BLK_W     = DATA_BITS + 1;
  localparam int NUM_BLKS  = 8;
  localparam int ADDR_W    = $clog2(NUM_BLKS);
  localparam int SETUP_CYC = 256;
  localparam int SETUP_W   = $clog2(SETUP_CYC);
  localparam int PER_W     = 8;
  localparam int IDX_W     = $clog2(DATA_BITS) + 1;

  typedef struct packed {
    logic              seqTerm;
    logic              blkTerm;
    logic [ADDR_W-1:0] lastBlk;
    logic [2:0]        rate;
  } mode_t;

  typedef struct packed {
    logic             loadMode;
    logic             emitData;
    logic             emitTerm;
    logic [IDX_W-1:0] bitSel;
  } ctl_t;

  function automatic mode_t decodeCfg(input logic [BLK_W-1:0] w);
    mode_t m;
    m.rate    = w[3:1];
    m.lastBlk = w[6:4];
    m.blkTerm = w[7];
    m.seqTerm = w[8];
    return m;
  endfunction

  function automatic logic [PER_W-1:0] periodOf(input logic [2:0] r);
    case (r)
      3'd0:    return PER_W'(8);
      3'd1:    return PER_W'(16);
      3'd2:    return PER_W'(32);
      3'd3:    return PER_W'(40);
      3'd4:    return PER_W'(50);
      3'd5:    return PER_W'(64);
      3'd6:    return PER_W'(100);
      default: return PER_W'(128);
    endcase
  endfunction
endpackage

// File: rtl/tagSeqDatapath.sv
module tagSeqDatapath
  import tag_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctl_t             ctl,
  input  logic [BLK_W-1:0] memData,
  output mode_t            curMode,
  output mode_t            cfgMode,
  output logic [PER_W-1:0] periodLen,
  output logic             txBit,
  output logic             termFlag,
  output logic             bitStrobe
);
  mode_t modeReg;

  assign cfgMode   = decodeCfg(memData);
  assign curMode   = modeReg;
  assign periodLen = periodOf(modeReg.rate);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg   <= '0;
      txBit     <= 1'b0;
      termFlag  <= 1'b0;
      bitStrobe <= 1'b0;
    end else begin
      bitStrobe <= ctl.emitData | ctl.emitTerm;
      if (ctl.loadMode) modeReg <= cfgMode;
      if (ctl.emitTerm) begin
        txBit    <= 1'b1;
        termFlag <= 1'b1;
      end else if (ctl.emitData) begin
        txBit    <= memData[ctl.bitSel];
        termFlag <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tagSeqControl.sv
module tagSeqControl
  import tag_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  mode_t             curMode,
  input  mode_t             cfgMode,
  input  logic [PER_W-1:0]  periodLen,
  input  logic              resumeLoad,
  input  logic [ADDR_W-1:0] resumeAddr,
  output ctl_t              ctl,
  output logic [ADDR_W-1:0] memAddr,
  output logic              modEnable
);
  typedef enum logic [1:0] {ST_SETUP, ST_REFRESH, ST_TERM, ST_DATA} state_t;

  state_t            state;
  logic [SETUP_W-1:0] setupCnt;
  logic [PER_W-1:0]  cnt;
  logic [IDX_W-1:0]  bitIdx;
  logic [ADDR_W-1:0] curBlock;
  logic              resumed;
  logic              termLeft;
  logic              inSeqTerm;

  mode_t             refMode;
  logic              termBefore;
  logic              periodEnd;
  logic              lastOne;
  logic [ADDR_W-1:0] nextBlk;

  assign refMode    = resumed ? curMode : cfgMode;
  assign termBefore = refMode.blkTerm | (resumed & refMode.seqTerm);
  assign periodEnd  = (cnt == periodLen - PER_W'(1));
  assign lastOne    = (curBlock >= curMode.lastBlk);
  assign nextBlk    = lastOne ? ADDR_W'(1) : curBlock + ADDR_W'(1);

  always_comb begin
    ctl.loadMode = (state == ST_REFRESH) && !resumed;
    ctl.emitData = (state == ST_DATA) && (cnt == '0);
    ctl.emitTerm = (state == ST_TERM) && (cnt == '0);
    ctl.bitSel   = bitIdx;
    memAddr      = (state == ST_DATA) ? curBlock : '0;
    modEnable    = (state != ST_SETUP);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_SETUP;
      setupCnt  <= '0;
      cnt       <= '0;
      bitIdx    <= IDX_W'(1);
      curBlock  <= ADDR_W'(1);
      resumed   <= 1'b0;
      termLeft  <= 1'b0;
      inSeqTerm <= 1'b0;
    end else if (resumeLoad && state != ST_SETUP) begin
      curBlock <= (resumeAddr == '0) ? ADDR_W'(1) : resumeAddr;
      resumed  <= 1'b1;
      cnt      <= '0;
      state    <= ST_REFRESH;
    end else begin
      case (state)
        ST_SETUP: begin
          setupCnt <= setupCnt + SETUP_W'(1);
          if (setupCnt == SETUP_W'(SETUP_CYC - 1)) state <= ST_REFRESH;
        end
        ST_REFRESH: begin
          resumed   <= 1'b0;
          cnt       <= '0;
          bitIdx    <= IDX_W'(1);
          termLeft  <= 1'b0;
          inSeqTerm <= 1'b0;
          state     <= termBefore ? ST_TERM : ST_DATA;
        end
        ST_TERM: begin
          if (periodEnd) begin
            cnt <= '0;
            if (termLeft)       termLeft <= 1'b0;
            else if (inSeqTerm) state    <= ST_REFRESH;
            else                state    <= ST_DATA;
          end else begin
            cnt <= cnt + PER_W'(1);
          end
        end
        default: begin
          if (periodEnd) begin
            cnt <= '0;
            if (bitIdx == IDX_W'(DATA_BITS)) begin
              curBlock <= nextBlk;
              if (lastOne && curMode.seqTerm) begin
                state     <= ST_TERM;
                inSeqTerm <= 1'b1;
                termLeft  <= 1'b1;
              end else begin
                state <= ST_REFRESH;
              end
            end else begin
              bitIdx <= bitIdx + IDX_W'(1);
            end
          end else begin
            cnt <= cnt + PER_W'(1);
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/tagReadSeq.sv
module tagReadSeq
  import tag_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [BLK_W-1:0]  memData,
  input  logic              resumeLoad,
  input  logic [ADDR_W-1:0] resumeAddr,
  output logic [ADDR_W-1:0] memAddr,
  output logic              txBit,
  output logic              bitStrobe,
  output logic              termFlag,
  output logic              modEnable
);
  ctl_t             ctl;
  mode_t            curMode;
  mode_t            cfgMode;
  logic [PER_W-1:0] periodLen;

  tagSeqControl ctrl_i (
    .clk(clk), .rstN(rstN), .curMode(curMode), .cfgMode(cfgMode),
    .periodLen(periodLen), .resumeLoad(resumeLoad), .resumeAddr(resumeAddr),
    .ctl(ctl), .memAddr(memAddr), .modEnable(modEnable)
  );

  tagSeqDatapath dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .memData(memData),
    .curMode(curMode), .cfgMode(cfgMode), .periodLen(periodLen),
    .txBit(txBit), .termFlag(termFlag), .bitStrobe(bitStrobe)
  );
endmodule

// File: rtl/tagSeqChecker.sv
module tagSeqChecker
  import tag_seq_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] memAddr,
  input logic              txBit,
  input logic              bitStrobe,
  input logic              termFlag,
  input logic              modEnable
);
  AST_SETUP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !modEnable |-> (!bitStrobe && memAddr == '0)); // R1
  AST_ENABLE_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    modEnable |=> modEnable); // R1
  AST_NO_BLOCK0_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (bitStrobe && !termFlag) |-> ($past(memAddr) != '0)); // R4
  AST_TERM_DAMPS: assert property (@(posedge clk) disable iff (!rstN)
    termFlag |-> txBit); // R6
  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    bitStrobe |=> !bitStrobe); // R9
  AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !bitStrobe |-> ($stable(txBit) && $stable(termFlag))); // R9
endmodule

bind tagReadSeq tagSeqChecker chk_i (
  .clk(clk), .rstN(rstN), .memAddr(memAddr), .txBit(txBit),
  .bitStrobe(bitStrobe), .termFlag(termFlag), .modEnable(modEnable)
);

// File: tb/tagReadSeq_tb_top.sv
`timescale 1ns/1ps
module tagReadSeq_tb_top;
  import tag_seq_pkg::*;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [BLK_W-1:0]  memData;
  logic              resumeLoad = 1'b0;
  logic [ADDR_W-1:0] resumeAddr = '0;
  logic [ADDR_W-1:0] memAddr;
  logic              txBit, bitStrobe, termFlag, modEnable;

  logic [BLK_W-1:0] mem [0:NUM_BLKS-1];
  assign memData = mem[memAddr];

  always #2.5 clk = ~clk;

  tagReadSeq dut_i (
    .clk(clk), .rstN(rstN), .memData(memData), .resumeLoad(resumeLoad),
    .resumeAddr(resumeAddr), .memAddr(memAddr), .txBit(txBit),
    .bitStrobe(bitStrobe), .termFlag(termFlag), .modEnable(modEnable)
  );

  int nChecks = 0;
  int nErrors = 0;
  bit done = 1'b0;

  int cycle = 0;
  always @(posedge clk) cycle <= cycle + 1;

  localparam int LOG_N = 4096;
  logic symT [0:LOG_N-1];
  logic symB [0:LOG_N-1];
  int   symTime [0:LOG_N-1];
  int   symCount = 0;

  always @(negedge clk) begin
    if (rstN && bitStrobe && symCount < LOG_N) begin
      symT[symCount]    = termFlag;
      symB[symCount]    = txBit;
      symTime[symCount] = cycle;
      symCount          = symCount + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycle);
    end
  endtask

  function automatic logic [BLK_W-1:0] cfgWord(input int rate, input int lb,
                                                input bit bt, input bit st);
    return {24'h0, st, bt, 3'(lb), 3'(rate), 1'b0};
  endfunction

  function automatic int perOf(input int rate);
    case (rate)
      0: return 8;   1: return 16;  2: return 32;  3: return 40;
      4: return 50;  5: return 64;  6: return 100; default: return 128;
    endcase
  endfunction

  // expected stream: element is 2 for terminator, else data bit
  int expSym [0:LOG_N-1];

  task automatic buildExpected(input int lb, input bit bt, input bit st, input int n);
    int blk = 1;
    int k = 0;
    int lastB = (lb == 0) ? 1 : lb;
    while (k < n) begin
      if (bt) begin expSym[k] = 2; k++; end
      for (int b = 1; b <= DATA_BITS; b++) begin
        if (k < n) begin expSym[k] = int'(mem[blk][b]); k++; end
      end
      if (blk >= lastB) begin
        if (st) begin
          if (k < n) begin expSym[k] = 2; k++; end
          if (k < n) begin expSym[k] = 2; k++; end
        end
        blk = 1;
      end else begin
        blk++;
      end
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  // vector: rate, lastBlk, bt, st
  typedef struct packed { logic [2:0] rate; logic [2:0] lb; logic bt; logic st; } vec_t;
  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{3'd0, 3'd2, 1'b0, 1'b0},
    '{3'd1, 3'd1, 1'b1, 1'b0},
    '{3'd2, 3'd3, 1'b0, 1'b1},
    '{3'd3, 3'd2, 1'b1, 1'b1},
    '{3'd4, 3'd1, 1'b1, 1'b1},
    '{3'd5, 3'd0, 1'b0, 1'b1},
    '{3'd6, 3'd1, 1'b0, 1'b0},
    '{3'd7, 3'd1, 1'b1, 1'b0}
  };

  initial begin
    #(200000 * 5);
    if (!done) begin
      nErrors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycle, 200000);
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    int base, base2, n, lastB, p, off;
    for (int b = 0; b < NUM_BLKS; b++)
      mem[b] = {32'(32'h9E3779B9 * (b + 1) + 32'h01234567), 1'b1};

    // R1: reset state and setup timing
    mem[0] = cfgWord(0, 1, 1'b0, 1'b0);
    repeat (2) @(negedge clk);
    check(!bitStrobe && !termFlag && !txBit && !modEnable && memAddr == 0,
          "R1 reset state", {bitStrobe, termFlag, txBit, modEnable}, 0);
    rstN = 1'b1;
    repeat (255) @(negedge clk);
    check(!modEnable, "R1 modEnable after 255 edges", modEnable, 0);
    check(memAddr == 0, "R1 memAddr in setup", memAddr, 0);
    @(negedge clk);
    check(modEnable, "R1 modEnable after 256 edges", modEnable, 1);
    check(!bitStrobe, "R1 no strobe at 256", bitStrobe, 0);
    @(negedge clk);
    check(!bitStrobe, "R1 no strobe at 257", bitStrobe, 0);
    @(negedge clk);
    check(bitStrobe, "R1 first strobe at 258", bitStrobe, 1);

    // R2 R3 R4 R6 R7: table of configurations
    for (int v = 0; v < NVEC; v++) begin
      mem[0] = cfgWord(VECS[v].rate, VECS[v].lb, VECS[v].bt, VECS[v].st);
      doReset();
      base  = symCount;
      lastB = (VECS[v].lb == 0) ? 1 : int'(VECS[v].lb);
      n     = 2 * (lastB * (32 + int'(VECS[v].bt)) + 2 * int'(VECS[v].st)) + 2;
      if (n > 160) n = 160;
      buildExpected(VECS[v].lb, VECS[v].bt, VECS[v].st, n);
      wait (symCount >= base + n);
      for (int k = 0; k < n; k++) begin
        int act;
        act = symT[base + k] ? 2 : int'(symB[base + k]);
        check(act == expSym[k], "R3 R4 R6 R7 stream symbol", act, expSym[k]);
      end
      p   = perOf(VECS[v].rate);
      off = VECS[v].bt ? 1 : 0;
      check(symTime[base + off + 1] - symTime[base + off] == p, "R2 bit period",
            symTime[base + off + 1] - symTime[base + off], p);
    end

    // R5: mode refreshed before each block
    mem[0] = cfgWord(0, 2, 1'b0, 1'b0);
    doReset();
    base = symCount;
    wait (symCount >= base + 1);
    mem[0] = cfgWord(0, 2, 1'b1, 1'b0);
    wait (symCount >= base + 34);
    check(!symT[base + 31], "R5 block1 last bit is data", symT[base + 31], 0);
    check(symT[base + 32], "R5 terminator after refresh", symT[base + 32], 1);
    check(symB[base + 33] == mem[2][1], "R5 block2 bit1", symB[base + 33], mem[2][1]);
    check(symTime[base + 32] - symTime[base + 31] == 9, "R5 refresh gap",
          symTime[base + 32] - symTime[base + 31], 9);

    // R8: resume at block 3 with old mode, new rate afterwards
    mem[0] = cfgWord(0, 3, 1'b0, 1'b1);
    doReset();
    base = symCount;
    wait (symCount >= base + 40);
    @(negedge clk);
    mem[0]     = cfgWord(1, 3, 1'b0, 1'b1);
    resumeAddr = 3'd3;
    resumeLoad = 1'b1;
    @(negedge clk);
    resumeLoad = 1'b0;
    base2 = symCount;
    wait (symCount >= base2 + 37);
    check(symT[base2], "R8 resumed block preceded by terminator", symT[base2], 1);
    for (int b = 1; b <= DATA_BITS; b++)
      check(!symT[base2 + b] && symB[base2 + b] == mem[3][b], "R8 resumed block3 data",
            symB[base2 + b], mem[3][b]);
    check(symTime[base2 + 2] - symTime[base2 + 1] == 8, "R8 old period kept",
          symTime[base2 + 2] - symTime[base2 + 1], 8);
    check(symT[base2 + 33] && symT[base2 + 34], "R7 sequence terminator pair",
          {symT[base2 + 33], symT[base2 + 34]}, 3);
    check(!symT[base2 + 35] && symB[base2 + 35] == mem[1][1], "R8 wrap to block1",
          symB[base2 + 35], mem[1][1]);
    check(symTime[base2 + 36] - symTime[base2 + 35] == 16, "R8 new period after block",
          symTime[base2 + 36] - symTime[base2 + 35], 16);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule